// File: doc/BRIEF.md
# Host Command Exchange Sequencer

This block runs one full command exchange, from the host side, with a slave device that shares a single signal wire. A separate link layer turns each request into line activity (tokens, flags and whole byte blocks) and returns single received bytes and whole received response blocks. The sequencer decides what is sent and when. It wakes the device and checks the sync byte that comes back. It sends the command flag and the command block, waits out the device's parse and execution times, and collects the response. A response whose CRC is bad is requested again by a bare transmit flag. Every exchange ends by putting the device to sleep.

Two timing modes are chosen per exchange. In long-execution mode the sequencer waits the parse time and then polls once with a transmit flag. A reply to that poll is an error code from the device. Silence means the command was accepted, so the sequencer waits the execution time before asking for the response. In short mode the poll is skipped and one wait of parse plus execution time is used. The wait times, the reply windows and the retry limit are parameters counted in clock cycles.

Top module: `host_xchg_seq`

## Requirements
- R1: A `start` pulse while idle begins an exchange. The first request is a wake token (`snd_kind` 0), followed by a transmit flag (`snd_kind` 1).
- R2: A sync reply of 8'h11 within `RX_WIN` cycles of the first transmit flag lets the exchange go on with a command flag (`snd_kind` 2) and then a command block (`snd_kind` 4). Any other byte, or no byte in the window, skips straight to the sleep flag and ends with status 1 (sync error).
- R3: In long-execution mode the poll transmit flag is requested `T_PARSE` cycles after the edge that accepts the block. A byte received in the next `RX_WIN` cycles ends the exchange with status 2, and `err_code` holds that byte.
- R4: In long-execution mode, if the poll gets no reply, the response transmit flag is requested `T_EXEC` cycles after that poll window closes.
- R5: In short mode no poll is sent. The response transmit flag is requested `T_PARSE + T_EXEC` cycles after the edge that accepts the block.
- R6: A response reported with a bad CRC, or no response within `RESP_WIN` cycles, causes only another transmit flag, at most `MAX_RETRY` times. When the resends are used up, the exchange ends with status 3 (CRC failure).
- R7: Every exchange ends with a sleep flag (`snd_kind` 3). In the cycle after that flag is accepted, `done` pulses for one cycle with the final status. A good-CRC response gives status 0.
- R8: Once `snd_req` is raised, it stays high with an unchanged `snd_kind` until a cycle in which `snd_ack` is high.
- R9: `start` has no effect while an exchange is in progress, and after `done` the block stays idle with no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exchange (honoured only when idle) |
| long_exec | input | 1 | Mode for this exchange: 1 = long execution with parse poll, 0 = short |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse at the end of an exchange |
| status | output | 2 | Final result: 0 ok, 1 sync error, 2 command error, 3 CRC failure |
| err_code | output | 8 | Error byte returned to the parse poll |
| snd_req | output | 1 | Send request to the link layer |
| snd_kind | output | 3 | What to send: 0 wake, 1 transmit, 2 command, 3 sleep, 4 command block |
| snd_ack | input | 1 | Link layer accepts the current request |
| rx_valid | input | 1 | Single received byte is valid |
| rx_byte | input | 8 | Single received byte |
| rsp_done | input | 1 | Response block fully received |
| rsp_crc_ok | input | 1 | CRC of that response block is good (valid with `rsp_done`) |

## Verification
The assertions check three things on every cycle. A send request holds steady until it is accepted. `done` only ever follows an accepted sleep flag. The retry counter never goes past its limit and is only bumped while a resend is still allowed. The poll error byte is also checked whenever it is captured, and the wait timer is checked to stop itself when it expires. The bench scenarios cover the rest: the order of tokens in each kind of exchange, the exact cycle distances of the parse, execution and poll windows in both modes, which outcome each reply pattern leads to, and that a `start` arriving mid-exchange changes nothing.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

    typedef enum logic [2:0] {
        TOK_WAKE  = 3'd0,
        TOK_XMIT  = 3'd1,
        TOK_CMD   = 3'd2,
        TOK_SLEEP = 3'd3,
        TOK_BLOCK = 3'd4
    } tok_e;

    typedef enum logic [1:0] {
        XS_OK       = 2'd0,
        XS_SYNC_ERR = 2'd1,
        XS_CMD_ERR  = 2'd2,
        XS_CRC_FAIL = 2'd3
    } xstat_e;

    typedef enum logic [3:0] {
        P_IDLE,
        P_WAKE,
        P_SYNC_TX,
        P_SYNC_WAIT,
        P_CMD_TX,
        P_BLOCK_TX,
        P_PARSE_WAIT,
        P_POLL_TX,
        P_POLL_WAIT,
        P_EXEC_WAIT,
        P_RESP_TX,
        P_RESP_WAIT,
        P_SLEEP,
        P_DONE
    } phase_e;

    localparam logic [7:0] SYNC_BYTE = 8'h11;

    // Phases in which a request is presented to the link layer
    function automatic logic phase_sends(phase_e p);
        case (p)
            P_WAKE, P_SYNC_TX, P_CMD_TX, P_BLOCK_TX,
            P_POLL_TX, P_RESP_TX, P_SLEEP: return 1'b1;
            default:                       return 1'b0;
        endcase
    endfunction

    function automatic tok_e phase_token(phase_e p);
        case (p)
            P_CMD_TX:   return TOK_CMD;
            P_BLOCK_TX: return TOK_BLOCK;
            P_SLEEP:    return TOK_SLEEP;
            P_SYNC_TX,
            P_POLL_TX,
            P_RESP_TX:  return TOK_XMIT;
            default:    return TOK_WAKE;
        endcase
    endfunction

endpackage

// File: rtl/xseq_timer.sv
module xseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         cancel,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic         act;

    // A load of value N gives an expiry pulse N cycles later
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            act <= 1'b0;
        end else if (load) begin
            cnt <= val;
            act <= 1'b1;
        end else if (cancel) begin
            act <= 1'b0;
        end else if (act) begin
            cnt <= cnt - 1'b1;
            if (cnt == W'(1)) act <= 1'b0;
        end
    end

    assign expire = act && (cnt == W'(1));

    AST_TMR_SELF_STOP: assert property (@(posedge clk) disable iff (rst)
        (act && cnt == W'(1) && !load) |=> !act); // R5

endmodule

// File: rtl/xseq_retry.sv
module xseq_retry #(
    parameter int MAX = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    output logic avail
);
    localparam int CW = $clog2(MAX + 1) + 1;

    logic [CW-1:0] used;

    always_ff @(posedge clk) begin
        if (rst || clr) used <= '0;
        else if (bump)  used <= used + 1'b1;
    end

    assign avail = used < CW'(MAX);

    AST_RETRY_ALLOWED: assert property (@(posedge clk) disable iff (rst)
        bump |-> avail); // R6
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        used <= CW'(MAX)); // R6

endmodule

// File: rtl/host_xchg_seq.sv
module host_xchg_seq
    import xseq_pkg::*;
#(
    parameter int T_PARSE   = 20,
    parameter int T_EXEC    = 60,
    parameter int RX_WIN    = 8,
    parameter int RESP_WIN  = 16,
    parameter int MAX_RETRY = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       long_exec,
    output logic       busy,
    output logic       done,
    output logic [1:0] status,
    output logic [7:0] err_code,
    output logic       snd_req,
    output logic [2:0] snd_kind,
    input  logic       snd_ack,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rsp_done,
    input  logic       rsp_crc_ok
);
    localparam int LONGEST = T_PARSE + T_EXEC + RX_WIN + RESP_WIN;
    localparam int TW      = $clog2(LONGEST + 1) + 1;

    phase_e       phase, nxt;
    logic         long_q;
    xstat_e       stat_q, stat_nv;
    logic         stat_set;
    logic [7:0]   err_q;
    logic         err_set;

    logic         tmr_load, tmr_cancel, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic         rt_clr, rt_bump, rt_avail;

    xseq_timer #(.W(TW)) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .val    (tmr_val),
        .cancel (tmr_cancel),
        .expire (tmr_exp)
    );

    xseq_retry #(.MAX(MAX_RETRY)) rty_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (rt_clr),
        .bump  (rt_bump),
        .avail (rt_avail)
    );

    always_comb begin
        nxt        = phase;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        tmr_cancel = 1'b0;
        rt_clr     = 1'b0;
        rt_bump    = 1'b0;
        stat_set   = 1'b0;
        stat_nv    = XS_OK;
        err_set    = 1'b0;
        case (phase)
            P_IDLE: if (start) begin
                nxt      = P_WAKE;
                rt_clr   = 1'b1;
                stat_set = 1'b1;
            end
            P_WAKE:    if (snd_ack) nxt = P_SYNC_TX;
            P_SYNC_TX: if (snd_ack) begin
                nxt      = P_SYNC_WAIT;
                tmr_load = 1'b1;
                tmr_val  = TW'(RX_WIN);
            end
            P_SYNC_WAIT: begin
                if (rx_valid) begin
                    tmr_cancel = 1'b1;
                    if (rx_byte == SYNC_BYTE) begin
                        nxt = P_CMD_TX;
                    end else begin
                        nxt      = P_SLEEP;
                        stat_set = 1'b1;
                        stat_nv  = XS_SYNC_ERR;
                    end
                end else if (tmr_exp) begin
                    nxt      = P_SLEEP;
                    stat_set = 1'b1;
                    stat_nv  = XS_SYNC_ERR;
                end
            end
            P_CMD_TX:   if (snd_ack) nxt = P_BLOCK_TX;
            P_BLOCK_TX: if (snd_ack) begin
                nxt      = P_PARSE_WAIT;
                tmr_load = 1'b1;
                tmr_val  = long_q ? TW'(T_PARSE) : TW'(T_PARSE + T_EXEC);
            end
            P_PARSE_WAIT: if (tmr_exp) nxt = long_q ? P_POLL_TX : P_RESP_TX;
            P_POLL_TX: if (snd_ack) begin
                nxt      = P_POLL_WAIT;
                tmr_load = 1'b1;
                tmr_val  = TW'(RX_WIN);
            end
            P_POLL_WAIT: begin
                if (rx_valid) begin
                    tmr_cancel = 1'b1;
                    err_set    = 1'b1;
                    stat_set   = 1'b1;
                    stat_nv    = XS_CMD_ERR;
                    nxt        = P_SLEEP;
                end else if (tmr_exp) begin
                    nxt      = P_EXEC_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_EXEC);
                end
            end
            P_EXEC_WAIT: if (tmr_exp) nxt = P_RESP_TX;
            P_RESP_TX: if (snd_ack) begin
                nxt      = P_RESP_WAIT;
                tmr_load = 1'b1;
                tmr_val  = TW'(RESP_WIN);
            end
            P_RESP_WAIT: begin
                if (rsp_done || tmr_exp) begin
                    tmr_cancel = rsp_done;
                    if (rsp_done && rsp_crc_ok) begin
                        nxt = P_SLEEP;
                    end else if (rt_avail) begin
                        rt_bump = 1'b1;
                        nxt     = P_RESP_TX;
                    end else begin
                        stat_set = 1'b1;
                        stat_nv  = XS_CRC_FAIL;
                        nxt      = P_SLEEP;
                    end
                end
            end
            P_SLEEP: if (snd_ack) nxt = P_DONE;
            P_DONE:  nxt = P_IDLE;
            default: nxt = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= P_IDLE;
            long_q <= 1'b0;
            stat_q <= XS_OK;
            err_q  <= '0;
        end else begin
            phase <= nxt;
            if (phase == P_IDLE && start) begin
                long_q <= long_exec;
                err_q  <= '0;
            end
            if (stat_set) stat_q <= stat_nv;
            if (err_set)  err_q  <= rx_byte;
        end
    end

    assign busy     = (phase != P_IDLE);
    assign done     = (phase == P_DONE);
    assign status   = stat_q;
    assign err_code = err_q;
    assign snd_req  = phase_sends(phase);
    assign snd_kind = phase_token(phase);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (snd_req && !snd_ack) |=> (snd_req && $stable(snd_kind))); // R8
    AST_DONE_AFTER_SLEEP: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(snd_req && snd_ack && snd_kind == TOK_SLEEP)); // R7
    AST_CMDERR_CODE: assert property (@(posedge clk) disable iff (rst)
        (phase == P_POLL_WAIT && rx_valid) |=> (err_code == $past(rx_byte))); // R3
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (!snd_req && !busy)); // R9

endmodule

// File: tb/host_xchg_seq_tb_top.sv
module host_xchg_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TP   = 20;
    localparam int TE   = 60;
    localparam int RXW  = 8;
    localparam int RSPW = 16;
    localparam int MAXR = 2;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, long_exec = 1'b0;
    logic snd_ack = 1'b0, rx_valid = 1'b0, rsp_done = 1'b0, rsp_crc_ok = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic busy, done, snd_req;
    logic [1:0] status;
    logic [7:0] err_code;
    logic [2:0] snd_kind;

    host_xchg_seq #(.T_PARSE(TP), .T_EXEC(TE), .RX_WIN(RXW), .RESP_WIN(RSPW),
                    .MAX_RETRY(MAXR)) dut_i (
        .clk(clk), .rst(rst), .start(start), .long_exec(long_exec),
        .busy(busy), .done(done), .status(status), .err_code(err_code),
        .snd_req(snd_req), .snd_kind(snd_kind), .snd_ack(snd_ack),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rsp_done(rsp_done),
        .rsp_crc_ok(rsp_crc_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;

    // scenario configuration of the simulated device
    bit cfg_long, cfg_sync_on, cfg_poll_on, cfg_silent;
    logic [7:0] cfg_sync_b, cfg_poll_b;
    int cfg_bad, cfg_delay;

    int lkind [32];
    int lcyc  [32];
    int ln = 0;
    int cd = 0, rtype = 0, xmit_n = 0, resp_n = 0, hold_err = 0, wt = 0;
    bit pend = 0;
    logic [2:0] pk;
    logic [7:0] rb;
    logic rok;

    // Link layer and device model
    always @(negedge clk) begin
        rx_valid = 1'b0;
        rsp_done = 1'b0;
        if (rst) begin
            snd_ack = 1'b0; cd = 0; pend = 0;
        end else begin
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    if (rtype == 1) begin rx_valid = 1'b1; rx_byte = rb; end
                    if (rtype == 2) begin rsp_done = 1'b1; rsp_crc_ok = rok; end
                end
            end
            if (snd_ack) begin
                snd_ack = 1'b0;
            end else if (snd_req) begin
                if (!pend) begin
                    pend = 1; pk = snd_kind; wt = cfg_delay;
                end else if (snd_kind != pk) begin
                    hold_err++;
                end
                if (wt == 0) begin
                    snd_ack = 1'b1;
                    pend = 0;
                    if (ln < 32) begin lkind[ln] = int'(pk); lcyc[ln] = cyc; ln++; end
                    if (pk == 3'd1) begin
                        xmit_n++;
                        rtype = 0;
                        if (xmit_n == 1) begin
                            if (cfg_sync_on) begin rtype = 1; rb = cfg_sync_b; end
                        end else if (cfg_long && xmit_n == 2) begin
                            if (cfg_poll_on) begin rtype = 1; rb = cfg_poll_b; end
                        end else begin
                            resp_n++;
                            if (!cfg_silent) begin rtype = 2; rok = (resp_n > cfg_bad); end
                        end
                        cd = 4;
                    end
                end else begin
                    wt--;
                end
            end else if (pend) begin
                hold_err++;
                pend = 0;
            end
        end
    end

    function automatic string seq_str();
        string s = "";
        for (int i = 0; i < ln; i++) begin
            case (lkind[i])
                0: s = {s, "W"};
                1: s = {s, "T"};
                2: s = {s, "C"};
                3: s = {s, "S"};
                4: s = {s, "B"};
                default: s = {s, "?"};
            endcase
        end
        return s;
    endfunction

    task automatic chk(string rq, bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_seq(string rq, string exp);
        string act = seq_str();
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s token order actual=%s expected=%s", rq, act, exp);
        end
    endtask

    int got_stat, got_err;

    task automatic run(bit lg, bit s_on, logic [7:0] s_b, bit p_on, logic [7:0] p_b,
                       int bad, bit silent, bit mid_start);
        bit seen = 0;
        cfg_long = lg; cfg_sync_on = s_on; cfg_sync_b = s_b; cfg_poll_on = p_on;
        cfg_poll_b = p_b; cfg_bad = bad; cfg_silent = silent;
        ln = 0; xmit_n = 0; resp_n = 0; hold_err = 0;
        @(negedge clk); start = 1'b1; long_exec = lg;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            start = (mid_start && i == 30);
            if (done) begin
                got_stat = int'(status); got_err = int'(err_code);
                seen = 1;
                break;
            end
        end
        start = 1'b0;
        chk("R7", seen, "done seen", int'(seen), 1);
        @(negedge clk);
        chk("R7", !done, "done pulse width", int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R1", !busy && !snd_req && !done, "reset quiet",
            int'({busy, snd_req, done}), 0);
    endtask

    task automatic t_short_ok();
        cfg_delay = 0;
        run(0, 1, 8'h11, 0, 8'h00, 0, 0, 0);
        chk_seq("R1", "WTCBTS");
        chk("R7", got_stat == 0, "status", got_stat, 0);
        chk("R5", lcyc[4] - lcyc[3] == TP + TE + 1, "block to transmit",
            lcyc[4] - lcyc[3], TP + TE + 1);
    endtask

    task automatic t_long_ok();
        cfg_delay = 0;
        run(1, 1, 8'h11, 0, 8'h00, 0, 0, 0);
        chk_seq("R4", "WTCBTTS");
        chk("R4", got_stat == 0, "status", got_stat, 0);
        chk("R3", lcyc[4] - lcyc[3] == TP + 1, "block to poll", lcyc[4] - lcyc[3], TP + 1);
        chk("R4", lcyc[5] - lcyc[4] == RXW + TE + 1, "poll to transmit",
            lcyc[5] - lcyc[4], RXW + TE + 1);
    endtask

    task automatic t_sync_bad();
        cfg_delay = 0;
        run(0, 1, 8'h5A, 0, 8'h00, 0, 0, 0);
        chk_seq("R2", "WTS");
        chk("R2", got_stat == 1, "wrong byte status", got_stat, 1);
        run(1, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        chk_seq("R2", "WTS");
        chk("R2", got_stat == 1, "no reply status", got_stat, 1);
    endtask

    task automatic t_cmd_err();
        cfg_delay = 0;
        run(1, 1, 8'h11, 1, 8'h0F, 0, 0, 0);
        chk_seq("R3", "WTCBTS");
        chk("R3", got_stat == 2, "status", got_stat, 2);
        chk("R3", got_err == 8'h0F, "err_code", got_err, 8'h0F);
    endtask

    task automatic t_crc();
        cfg_delay = 0;
        run(0, 1, 8'h11, 0, 8'h00, 1, 0, 0);
        chk_seq("R6", "WTCBTTS");
        chk("R6", got_stat == 0, "one bad status", got_stat, 0);
        run(1, 1, 8'h11, 0, 8'h00, 2, 0, 0);
        chk_seq("R6", "WTCBTTTTS");
        chk("R6", got_stat == 0, "two bad status", got_stat, 0);
        run(0, 1, 8'h11, 0, 8'h00, 3, 0, 0);
        chk_seq("R6", "WTCBTTTS");
        chk("R6", got_stat == 3, "exhausted status", got_stat, 3);
        run(0, 1, 8'h11, 0, 8'h00, 0, 1, 0);
        chk_seq("R6", "WTCBTTTS");
        chk("R6", got_stat == 3, "silent status", got_stat, 3);
    endtask

    task automatic t_ack_delay();
        cfg_delay = 3;
        run(0, 1, 8'h11, 0, 8'h00, 0, 0, 0);
        chk_seq("R8", "WTCBTS");
        chk("R8", hold_err == 0, "request held", hold_err, 0);
        cfg_delay = 0;
    endtask

    task automatic t_start_busy();
        int n0;
        cfg_delay = 0;
        run(0, 1, 8'h11, 0, 8'h00, 0, 0, 1);
        chk_seq("R9", "WTCBTS");
        chk("R9", got_stat == 0, "status", got_stat, 0);
        n0 = ln;
        repeat (10) @(negedge clk);
        chk("R9", !busy && !snd_req && ln == n0, "idle after done",
            int'({busy, snd_req}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cfg_delay = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short_ok();
        t_long_ok();
        t_sync_bad();
        t_cmd_err();
        t_crc();
        t_ack_delay();
        t_start_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule